// File: doc/BRIEF.md
# Row capture buffer with strobed host readout

The block stores one row of 8-bit image samples in on-chip RAM at sensor rate. It then keeps that row unchanged while a slow host reads it back one byte at a time over an 8-bit parallel bus. The host controls the transfer with three lines:

- An acquire line starts a capture.
- A latch line puts the byte at the current read position onto the bus.
- A next line tells the block that the host has taken the byte, so the block moves on to the following one.

The sensor side writes one sample for every cycle in which its valid input is high and never stalls. A busy output is high while a capture is running, so the host can poll for completion. An end-of-row output marks the final byte.

The `PING_PONG` parameter selects between one and two banks. With two banks, the acquire command swaps them. The row just captured becomes the readable bank, and the sensor fills the other bank while the host drains it.

The host lines are asynchronous to the clock. Each one is synchronised and edge-detected, so a pulse acts exactly once however long it is held. The sensor stream is synchronous to the clock.

Top module: `row_capture_buf`

## Requirements
- R1: While rst_ni is low, bus_o is 0, busy_o is 0 and last_o is 0, and both the read and the write position are cleared.
- R2: A rising edge on acq_i while no capture runs raises busy_o. busy_o then stays high until exactly ROW_LEN cycles with pix_valid_i high have been stored, and it falls on the clock edge that stores the last of them. Cycles with pix_valid_i low store nothing.
- R3: A rising edge on lat_i while a row is readable puts the byte at the current read position on bus_o. bus_o then holds that byte until the next accepted strobe, and a latch pulse acts once whatever its width.
- R4: Each rising edge on nxt_i after a latch advances the read position by one and puts the following stored byte on bus_o, once per pulse whatever its width.
- R5: last_o is high exactly while the byte at position ROW_LEN-1 is on bus_o. A further next pulse in that state leaves bus_o and last_o unchanged.
- R6: Samples with pix_valid_i high outside a capture are not stored. A row read out after such samples equals the row captured before them.
- R7: A rising edge on acq_i during a capture is ignored: the capture neither restarts nor ends early.
- R8: With PING_PONG=1, an acquire command after a completed capture makes that row readable at once. The host can latch and step through it while busy_o is high and the other bank is being filled, and the next acquire makes the newer row readable.
- R9: With PING_PONG=0, latch and next pulses during a capture leave bus_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_data_i | input | DATA_W | Sensor sample |
| pix_valid_i | input | 1 | Sample valid, one sample per high cycle |
| acq_i | input | 1 | Host acquire command (asynchronous) |
| lat_i | input | 1 | Host latch strobe (asynchronous) |
| nxt_i | input | 1 | Host next-byte strobe (asynchronous) |
| bus_o | output | DATA_W | Byte presented to the host |
| busy_o | output | 1 | High while a capture is running |
| last_o | output | 1 | High while the final byte of the row is on the bus |

## Verification
The hardest case to reach is the two-bank overlap. The host must read one bank while the sensor writes the other, and that needs a completed row, a bank swap and a capture in flight all at the same moment.

The stimulus gets there in four steps:
1. Fill bank A.
2. Issue a second acquire, which swaps the banks.
3. Latch while busy_o is high.
4. Stream the second row between next pulses.

The expected bytes of both rows sit in one queue in capture order, which shows that neither bank disturbs the other. In single-bank mode, strobes and an extra acquire are injected halfway through a capture. The bench then checks that the capture finishes at exactly the original sample count and returns the original data.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_READY,
    ST_READOUT
  } rcb_state_e;
endpackage

// File: rtl/rcb_strobe_sync.sv
module rcb_strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], strobe_i};
  end

  // sh_q[1] is the second synchroniser stage, sh_q[2] its delayed copy
  assign pulse_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rcb_bank_ram.sv
module rcb_bank_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1500,
  parameter int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // output register doubles as the host bus holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/row_capture_buf.sv
module row_capture_buf
  import rcb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ROW_LEN   = 1500,
  parameter bit PING_PONG = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              pix_valid_i,
  input  logic              acq_i,
  input  logic              lat_i,
  input  logic              nxt_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              busy_o,
  output logic              last_o
);
  localparam int BANKS  = PING_PONG ? 2 : 1;
  localparam int DEPTH  = BANKS * ROW_LEN;
  localparam int COL_W  = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
  localparam int MEM_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [COL_W-1:0]  LAST_COL = COL_W'(ROW_LEN - 1);
  localparam logic [MEM_AW-1:0] BANK_OFS = MEM_AW'(ROW_LEN);

  rcb_state_e        state_q;
  logic [COL_W-1:0]  wr_col_q, rd_col_q, rd_col_sel;
  logic              pres_q;
  logic              wr_bank_q, rd_bank, rd_ok;
  logic              acq_p, lat_p, nxt_p;
  logic              acq_ok, lat_go, nxt_go, rd_en, we, row_done;
  logic [MEM_AW-1:0] waddr, raddr;

  // host strobe synchronisers: 0 acquire, 1 latch, 2 next
  logic [2:0] strb_raw, strb_pulse;
  assign strb_raw = {nxt_i, lat_i, acq_i};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    rcb_strobe_sync u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(strb_raw[g]),
      .pulse_o (strb_pulse[g])
    );
  end

  assign acq_p = strb_pulse[0];
  assign lat_p = strb_pulse[1];
  assign nxt_p = strb_pulse[2];

  assign row_done = (state_q == ST_READY) || (state_q == ST_READOUT);
  assign acq_ok   = acq_p && (state_q != ST_CAPTURE);
  assign we       = (state_q == ST_CAPTURE) && pix_valid_i;

  if (PING_PONG) begin : g_pp
    logic bank_q, avail_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bank_q  <= 1'b0;
        avail_q <= 1'b0;
      end else if (acq_ok) begin
        bank_q  <= ~bank_q;
        avail_q <= row_done;
      end
    end
    assign wr_bank_q = bank_q;
    assign rd_bank   = ~bank_q;
    assign rd_ok     = avail_q;
  end else begin : g_single
    assign wr_bank_q = 1'b0;
    assign rd_bank   = 1'b0;
    assign rd_ok     = row_done;
  end

  assign lat_go     = lat_p && rd_ok && !acq_ok;
  assign nxt_go     = nxt_p && rd_ok && !acq_ok && pres_q && (rd_col_q != LAST_COL);
  assign rd_en      = lat_go || nxt_go;
  assign rd_col_sel = nxt_go ? rd_col_q + 1'b1 : rd_col_q;

  assign waddr = MEM_AW'(wr_col_q) + (wr_bank_q ? BANK_OFS : '0);
  assign raddr = MEM_AW'(rd_col_sel) + (rd_bank ? BANK_OFS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_col_q <= '0;
      rd_col_q <= '0;
      pres_q   <= 1'b0;
    end else begin
      if (acq_ok) begin
        state_q  <= ST_CAPTURE;
        wr_col_q <= '0;
        rd_col_q <= '0;
        pres_q   <= 1'b0;
      end else begin
        if (we) begin
          if (wr_col_q == LAST_COL) begin
            wr_col_q <= '0;
            state_q  <= ST_READY;
          end else begin
            wr_col_q <= wr_col_q + 1'b1;
          end
        end
        if (lat_go) begin
          pres_q <= 1'b1;
          if (state_q == ST_READY) state_q <= ST_READOUT;
        end
        if (nxt_go) rd_col_q <= rd_col_sel;
      end
    end
  end

  rcb_bank_ram #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH),
    .AW    (MEM_AW)
  ) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(pix_data_i),
    .re_i   (rd_en),
    .raddr_i(raddr),
    .rdata_o(bus_o)
  );

  assign busy_o = (state_q == ST_CAPTURE);
  assign last_o = pres_q && (rd_col_q == LAST_COL);
endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
  parameter int DATA_W    = 8,
  parameter bit PING_PONG = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pix_valid_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              busy_o,
  input logic              last_o,
  input logic              acq_p,
  input logic              lat_p,
  input logic              nxt_p,
  input logic              we
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_outputs_R1: assert (bus_o == '0 && !busy_o && !last_o);
    end
  end

  assert_busy_ends_on_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !pix_valid_i |=> busy_o);

  assert_bus_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_p && !nxt_p |=> $stable(bus_o));

  assert_last_saturates_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && nxt_p && !lat_p && !acq_p |=> $stable(bus_o) && last_o);

  assert_no_store_outside_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !we);

  assert_acq_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && acq_p && !pix_valid_i |=> busy_o);

  if (!PING_PONG) begin : g_single_chk
    assert_bus_frozen_in_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(bus_o));
  end
endmodule

bind row_capture_buf rcb_checker #(
  .DATA_W   (DATA_W),
  .PING_PONG(PING_PONG)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .bus_o      (bus_o),
  .busy_o     (busy_o),
  .last_o     (last_o),
  .acq_p      (acq_p),
  .lat_p      (lat_p),
  .nxt_p      (nxt_p),
  .we         (we)
);

// File: tb/sim_row_capture_buf.sv
module sim_row_capture_buf;
  localparam int ROW = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pix_data = '0;
  logic       pix_valid = 1'b0;
  logic [5:0] st = '0;  // 0 acq0, 1 lat0, 2 nxt0, 3 acq1, 4 lat1, 5 nxt1
  logic [7:0] bus0, bus1;
  logic       busy0, busy1, last0, last1;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  row_capture_buf #(.DATA_W(8), .ROW_LEN(ROW), .PING_PONG(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pix_data_i(pix_data), .pix_valid_i(pix_valid),
    .acq_i(st[0]), .lat_i(st[1]), .nxt_i(st[2]),
    .bus_o(bus0), .busy_o(busy0), .last_o(last0)
  );

  row_capture_buf #(.DATA_W(8), .ROW_LEN(ROW), .PING_PONG(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .pix_data_i(pix_data), .pix_valid_i(pix_valid),
    .acq_i(st[3]), .lat_i(st[4]), .nxt_i(st[5]),
    .bus_o(bus1), .busy_o(busy1), .last_o(last1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int which, input int width);
    @(negedge clk);
    st[which] = 1'b1;
    repeat (width) @(negedge clk);
    st[which] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // driver: streams samples, pushing expected bytes into the scoreboard
  task automatic send(input logic [7:0] base, input int n, input int gap, input bit push);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_data  = base + 8'(i);
      pix_valid = 1'b1;
      if (push) exp_q.push_back(base + 8'(i));
      @(negedge clk);
      pix_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  // monitor: pops the expected byte and compares the bus
  task automatic compare(input bit u, input bit is_last, input string req);
    logic [7:0] e;
    logic [7:0] b;
    logic       l;
    e = exp_q.pop_front();
    b = u ? bus1 : bus0;
    l = u ? last1 : last0;
    chk(b == e, req, b, e);
    chk(l == is_last, "R5 last_o", l, is_last);
  endtask

  task automatic read_row(input bit u, input string req);
    strobe(u ? 4 : 1, 3);
    compare(u, 1'b0, {req, " first byte (R3)"});
    for (int i = 1; i < ROW; i++) begin
      strobe(u ? 5 : 2, (i % 3) + 1);
      compare(u, i == ROW - 1, {req, " next byte (R4)"});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    repeat (3) @(negedge clk);
    chk(bus0 == 8'h00, "R1 bus in reset", bus0, 0);
    chk(busy0 == 1'b0, "R1 busy in reset", busy0, 0);
    chk(last0 == 1'b0, "R1 last in reset", last0, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // single bank: first capture with gaps, mid-capture strobes and acquire
    strobe(0, 2);
    chk(busy0 == 1'b1, "R2 busy after acquire", busy0, 1);
    send(8'h10, 4, 1, 1'b1);
    strobe(1, 2);
    chk(bus0 == 8'h00, "R9 latch during capture", bus0, 0);
    strobe(0, 3);
    chk(busy0 == 1'b1, "R7 acquire during capture", busy0, 1);
    send(8'h14, 3, 2, 1'b1);
    chk(busy0 == 1'b1, "R2 busy before last sample", busy0, 1);
    send(8'h17, 1, 0, 1'b1);
    chk(busy0 == 1'b0, "R2 busy after last sample", busy0, 0);

    // samples outside capture must not be stored
    send(8'hE0, ROW, 0, 1'b0);
    chk(busy0 == 1'b0, "R6 no capture without acquire", busy0, 0);

    read_row(1'b0, "R6 frozen row");
    hold = bus0;
    repeat (10) @(negedge clk);
    chk(bus0 == hold, "R3 bus holds", bus0, hold);
    strobe(2, 2);
    chk(bus0 == hold, "R5 next after last", bus0, hold);
    chk(last0 == 1'b1, "R5 last stays", last0, 1);

    // second capture, strobes during capture must not disturb bus
    strobe(0, 1);
    chk(busy0 == 1'b1, "R2 busy second acquire", busy0, 1);
    send(8'h40, 3, 0, 1'b1);
    strobe(1, 1);
    strobe(2, 1);
    chk(bus0 == hold, "R9 strobes during capture", bus0, hold);
    send(8'h43, ROW - 3, 0, 1'b1);
    chk(busy0 == 1'b0, "R2 second capture done", busy0, 0);
    read_row(1'b0, "R2 new row");

    // ping-pong instance
    strobe(3, 2);
    chk(busy1 == 1'b1, "R8 pp busy", busy1, 1);
    send(8'h80, ROW, 0, 1'b1);
    chk(busy1 == 1'b0, "R8 pp bank A done", busy1, 0);
    strobe(3, 1);
    chk(busy1 == 1'b1, "R8 pp swap starts capture", busy1, 1);
    strobe(4, 2);
    chk(busy1 == 1'b1, "R8 read while capturing", busy1, 1);
    compare(1'b1, 1'b0, "R8 bank A byte 0");
    send(8'hC0, ROW, 1, 1'b1);
    chk(busy1 == 1'b0, "R8 pp bank B done", busy1, 0);
    for (int i = 1; i < ROW; i++) begin
      strobe(5, 1);
      compare(1'b1, i == ROW - 1, "R8 bank A byte");
    end
    strobe(3, 1);
    read_row(1'b1, "R8 bank B");
    chk(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule